// File: doc/BRIEF.md
# Serial Real-Time-Clock Command Port

This block is the device side of a real-time clock that software reaches through a 4-bit general-purpose pin register. Software writes the register. Each write is ANDed with a 4-bit direction register, and the result is seen as three wires: a shift clock, a bidirectional serial data bit and a chip select. The block watches these levels from one write to the next. It detects the opening of a transaction and collects an 8-bit command, which may be sent in either bit order. It then moves whole bytes into or out of one of three clock registers: a one-byte control register, a seven-byte calendar-and-time register and a three-byte time-only register.

The value kept in the pin register is the value the block hands back. During a read, the block can therefore place a data bit on the serial data pin, and software samples it by reading the pin register. The seven calendar fields and the three time fields share storage: the hour, minute and second bytes are the same in both views. Counting time and raising interrupts are not part of this block.

The controller has four states. ST_IDLE waits for a transaction to open. ST_CMD collects the command byte. ST_WR accepts payload bytes. ST_RD returns payload bytes. The transitions are:
- ST_IDLE→ST_CMD when chip select rises while the stored clock level is high.
- ST_CMD→ST_WR or ST_CMD→ST_RD on the eighth command bit with a valid select.
- ST_CMD→ST_IDLE on the eighth bit for the reset select or an unknown select.
- ST_WR or ST_RD→ST_IDLE after the last bit of the last byte.
- Any busy state→ST_IDLE when chip select goes low.

Top module: `rtc_serial_if`

## Requirements
- R1: On a pin write, the stored pin value becomes the written value ANDed with the direction register. The only exception is the serial data bit during a read. Bit 0 is the shift clock, bit 1 is serial data, bit 2 is chip select, and bit 3 is carried through under its direction bit. A direction write takes effect for later pin writes. After reset both registers are 0.
- R2: In ST_IDLE, a command opens only when the stored clock bit is 1, the stored chip select is 0 and the new chip select is 1. A chip-select rise while the stored clock bit is 0 opens nothing, and the bits that follow change no register.
- R3: In ST_CMD, ST_WR and ST_RD, a bit is taken or given only on a clock rise: the stored clock bit is 0 and the new one is 1. Data changes while the clock stays high have no effect.
- R4: Command bits arrive LSB first. If the assembled byte has 0x6 in bits 7:4 it is used as is. Otherwise its eight bits are mirrored before decoding.
- R5: In the decoded command, bit 0 is 1 for a read and 0 for a write, and bits 3:1 are the select. Select 0 is a reset: it clears the control byte to 0, leaves every calendar and time byte unchanged, and returns to ST_IDLE.
- R6: Select 1 is control (1 byte). Select 2 is calendar-and-time (7 bytes: year, month, day, weekday, hour, minute, second). Select 3 is time (3 bytes: hour, minute, second). Write payload bits arrive LSB first. Each complete byte is stored into the field for its byte position. After the last byte the block returns to ST_IDLE.
- R7: In ST_RD, every clock rise puts the next payload bit, LSB first and byte by byte in the R6 order, on bit 1 of the stored pin value. After the last bit the block returns to ST_IDLE.
- R8: A select of 4 to 7 returns the block to ST_IDLE and changes no register.
- R9: Chip select going low in ST_CMD, ST_WR or ST_RD returns the block to ST_IDLE. A partly received byte is dropped. This takes priority over a clock rise in the same write. The next transaction starts at byte 0.
- R10: After reset the block is in ST_IDLE and all eleven clock bytes read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_we | input | 1 | Strobe that loads the direction register |
| dir_wdata | input | 4 | New direction mask, 1 = software drives the bit |
| data_we | input | 1 | Strobe for a pin-register write |
| data_wdata | input | 4 | Pin value written by software |
| data_q | output | 4 | Stored pin value as handed back by the clock logic |

## Verification
Two things can fall in the same pin write: a clock rise that completes the last bit of a byte, and chip select dropping. The bench provokes this by sending seven bits of a control write and then writing one value that raises the clock and lowers chip select together. It then reads the control byte back through a normal read transaction and expects the old value, which shows the abort took priority. A second overlap is a data change while the clock is held high, sent after every command and payload bit. Read-back of each affected register shows that no extra bit was taken.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int PIN_W      = 4;
    localparam int BYTE_W     = 8;
    localparam int NUM_FIELDS = 8;
    localparam int BIT_IDX_W  = $clog2(BYTE_W);
    localparam int FLD_IDX_W  = $clog2(NUM_FIELDS);
    localparam int FLAT_W     = NUM_FIELDS * BYTE_W;
    localparam int SEL_W      = 3;

    localparam int PIN_SCK = 0;
    localparam int PIN_SIO = 1;
    localparam int PIN_CS  = 2;

    localparam logic [3:0] CMD_TAG = 4'h6;

    localparam logic [SEL_W-1:0] SEL_RESET    = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CTRL     = 3'd1;
    localparam logic [SEL_W-1:0] SEL_DATETIME = 3'd2;
    localparam logic [SEL_W-1:0] SEL_TIME     = 3'd3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_WR,
        ST_RD
    } rtc_state_e;

    // first storage slot of each register view
    function automatic logic [FLD_IDX_W-1:0] sel_base(input logic [SEL_W-1:0] sel);
        case (sel)
            SEL_DATETIME: return FLD_IDX_W'(1);
            SEL_TIME:     return FLD_IDX_W'(5);
            default:      return FLD_IDX_W'(0);
        endcase
    endfunction

    // index of the final byte of each register view
    function automatic logic [FLD_IDX_W-1:0] sel_last(input logic [SEL_W-1:0] sel);
        case (sel)
            SEL_DATETIME: return FLD_IDX_W'(6);
            SEL_TIME:     return FLD_IDX_W'(2);
            default:      return FLD_IDX_W'(0);
        endcase
    endfunction
endpackage

// File: rtl/rtc_cmd_decode.sv
module rtc_cmd_decode
    import rtc_pkg::*;
(
    input  logic [BYTE_W-1:0] raw_byte,
    output logic              is_read,
    output logic [SEL_W-1:0]  sel
);
    logic [BYTE_W-1:0] mirrored;
    logic [BYTE_W-1:0] norm;

    for (genvar g = 0; g < BYTE_W; g++) begin : g_mirror
        assign mirrored[g] = raw_byte[BYTE_W-1-g];
    end

    assign norm    = (raw_byte[BYTE_W-1 -: 4] == CMD_TAG) ? raw_byte : mirrored;
    assign is_read = norm[0];
    assign sel     = norm[SEL_W:1];
endmodule

// File: rtl/rtc_field_store.sv
module rtc_field_store
    import rtc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [FLD_IDX_W-1:0] wr_idx,
    input  logic [BYTE_W-1:0]    wr_byte,
    input  logic                 clr_ctrl,
    input  logic [FLD_IDX_W-1:0] rd_idx,
    input  logic [BIT_IDX_W-1:0] rd_bit,
    output logic                 rd_val,
    output logic [FLAT_W-1:0]    fields_flat
);
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && wr_idx == FLD_IDX_W'(g))
                q <= wr_byte;
            else if (clr_ctrl && (g == 0))
                q <= '0;
        end
        assign fields_flat[g*BYTE_W +: BYTE_W] = q;
    end

    assign rd_val = fields_flat[{rd_idx, rd_bit}];
endmodule

// File: rtl/rtc_serial_if.sv
module rtc_serial_if
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_we,
    input  logic [PIN_W-1:0] dir_wdata,
    input  logic             data_we,
    input  logic [PIN_W-1:0] data_wdata,
    output logic [PIN_W-1:0] data_q
);
    rtc_state_e            state_q, state_d;
    logic [PIN_W-1:0]      dir_q;
    logic [PIN_W-1:0]      data_d;
    logic [BIT_IDX_W-1:0]  bit_q, bit_d;
    logic [FLD_IDX_W-1:0]  byte_q, byte_d;
    logic [SEL_W-1:0]      sel_q, sel_d;
    logic [BYTE_W-1:0]     shift_q, shift_d;

    logic [PIN_W-1:0]      masked;
    logic                  sck_rise, cs_new, sio_new;
    logic [BYTE_W-1:0]     full_byte;
    logic                  dec_read;
    logic [SEL_W-1:0]      dec_sel;
    logic [FLD_IDX_W-1:0]  fld_idx;
    logic                  last_bit, last_byte;
    logic                  wr_en, clr_ctrl, rd_val;
    logic [FLAT_W-1:0]     fields_flat;

    assign masked    = data_wdata & dir_q;
    assign cs_new    = masked[PIN_CS];
    assign sio_new   = masked[PIN_SIO];
    assign sck_rise  = data_we && !data_q[PIN_SCK] && masked[PIN_SCK];
    assign full_byte = {sio_new, shift_q[BYTE_W-2:0]};
    assign fld_idx   = sel_base(sel_q) + byte_q;
    assign last_bit  = (bit_q == BIT_IDX_W'(BYTE_W - 1));
    assign last_byte = (byte_q == sel_last(sel_q));

    rtc_cmd_decode u_dec (
        .raw_byte (full_byte),
        .is_read  (dec_read),
        .sel      (dec_sel)
    );

    rtc_field_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (fld_idx),
        .wr_byte     (full_byte),
        .clr_ctrl    (clr_ctrl),
        .rd_idx      (fld_idx),
        .rd_bit      (bit_q),
        .rd_val      (rd_val),
        .fields_flat (fields_flat)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= '0;
            data_q  <= '0;
            bit_q   <= '0;
            byte_q  <= '0;
            sel_q   <= '0;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            if (dir_we)  dir_q  <= dir_wdata;
            if (data_we) data_q <= data_d;
            bit_q   <= bit_d;
            byte_q  <= byte_d;
            sel_q   <= sel_d;
            shift_q <= shift_d;
        end
    end

    // transitions and shift bookkeeping
    always_comb begin
        state_d  = state_q;
        bit_d    = bit_q;
        byte_d   = byte_q;
        sel_d    = sel_q;
        shift_d  = shift_q;
        wr_en    = 1'b0;
        clr_ctrl = 1'b0;
        if (data_we) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (data_q[PIN_SCK] && !data_q[PIN_CS] && cs_new) begin
                        state_d = ST_CMD;
                        bit_d   = '0;
                        shift_d = '0;
                    end
                end
                ST_CMD: begin
                    if (!cs_new) begin
                        state_d = ST_IDLE;
                    end else if (sck_rise) begin
                        shift_d[bit_q] = sio_new;
                        bit_d          = bit_q + 1'b1;
                        if (last_bit) begin
                            shift_d = '0;
                            byte_d  = '0;
                            sel_d   = dec_sel;
                            if (dec_sel == SEL_RESET) begin
                                clr_ctrl = 1'b1;
                                state_d  = ST_IDLE;
                            end else if (dec_sel == SEL_CTRL || dec_sel == SEL_DATETIME ||
                                         dec_sel == SEL_TIME) begin
                                state_d = dec_read ? ST_RD : ST_WR;
                            end else begin
                                state_d = ST_IDLE;
                            end
                        end
                    end
                end
                ST_WR: begin
                    if (!cs_new) begin
                        state_d = ST_IDLE;
                        byte_d  = '0;
                    end else if (sck_rise) begin
                        shift_d[bit_q] = sio_new;
                        bit_d          = bit_q + 1'b1;
                        if (last_bit) begin
                            wr_en   = 1'b1;
                            shift_d = '0;
                            byte_d  = byte_q + 1'b1;
                            if (last_byte) begin
                                byte_d  = '0;
                                state_d = ST_IDLE;
                            end
                        end
                    end
                end
                ST_RD: begin
                    if (!cs_new) begin
                        state_d = ST_IDLE;
                        byte_d  = '0;
                    end else if (sck_rise) begin
                        bit_d = bit_q + 1'b1;
                        if (last_bit) begin
                            byte_d = byte_q + 1'b1;
                            if (last_byte) begin
                                byte_d  = '0;
                                state_d = ST_IDLE;
                            end
                        end
                    end
                end
            endcase
        end
    end

    // returned pin value
    always_comb begin
        data_d = masked;
        if (state_q == ST_RD && cs_new && sck_rise)
            data_d[PIN_SIO] = rd_val;
    end
endmodule

// File: rtl/rtc_serial_if_chk.sv
module rtc_serial_if_chk
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              data_we,
    input logic [PIN_W-1:0]  data_wdata,
    input logic [PIN_W-1:0]  dir_q,
    input logic [PIN_W-1:0]  data_q,
    input rtc_state_e        state_q,
    input logic [FLAT_W-1:0] fields_flat
);
    p_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && state_q != ST_RD) |=> data_q == ($past(data_wdata) & $past(dir_q)));

    p_no_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && (!data_we || !data_q[PIN_SCK])) |=> state_q == ST_IDLE);

    p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !data_we |=> ($stable(data_q) && $stable(state_q)));

    p_fields_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_WR |=> $stable(fields_flat[FLAT_W-1:BYTE_W]));

    p_cs_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && data_we && !(data_wdata[PIN_CS] && dir_q[PIN_CS]))
        |=> state_q == ST_IDLE);
endmodule

bind rtc_serial_if rtc_serial_if_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_we     (data_we),
    .data_wdata  (data_wdata),
    .dir_q       (dir_q),
    .data_q      (data_q),
    .state_q     (state_q),
    .fields_flat (fields_flat)
);

// File: tb/rtc_serial_if_tb_top.sv
module rtc_serial_if_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_we = 1'b0, data_we = 1'b0;
    logic [3:0] dir_wdata = '0, data_wdata = '0;
    logic [3:0] data_q;

    always #2 clk = ~clk;

    rtc_serial_if dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_we     (dir_we),
        .dir_wdata  (dir_wdata),
        .data_we    (data_we),
        .data_wdata (data_wdata),
        .data_q     (data_q)
    );

    int         n_vec = 0, n_bad = 0;
    logic [3:0] exp_q[$];
    string      tag_q[$];
    logic       we_seen = 1'b0;
    logic [3:0] cur_dir = '0;
    logic [7:0] mdl [8];
    logic [7:0] wb  [7];

    // monitor: compare each pin write one edge later
    always @(posedge clk) we_seen <= data_we;
    always @(negedge clk) begin
        if (we_seen && exp_q.size() > 0) begin
            logic [3:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (data_q !== e) begin
                n_bad++;
                $display("FAIL %s: data_q=%h expected %h", t, data_q, e);
            end
        end
    end

    function automatic logic [3:0] pin(input logic cs, input logic sio, input logic sck);
        return {1'b0, cs, sio, sck};
    endfunction

    task automatic put(input logic [3:0] v, input logic [3:0] e, input string t);
        @(negedge clk);
        data_we    = 1'b1;
        data_wdata = v;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        data_we = 1'b0;
    endtask

    task automatic p(input logic [3:0] v, input string t);
        put(v, v & cur_dir, t);
    endtask

    task automatic set_dir(input logic [3:0] d);
        @(negedge clk);
        dir_we    = 1'b1;
        dir_wdata = d;
        cur_dir   = d;
        @(negedge clk);
        dir_we = 1'b0;
    endtask

    task automatic start_cmd(input string t);
        p(pin(0, 0, 1), t);
        p(pin(1, 0, 1), t);
    endtask

    task automatic end_xfer(input string t);
        p(pin(0, 0, 1), t);
    endtask

    // low, rise, then a data flip while clock stays high (R3)
    task automatic send_bit(input logic b, input string t);
        p(pin(1, b, 0), t);
        p(pin(1, b, 1), t);
        p(pin(1, ~b, 1), "R3");
    endtask

    task automatic send_byte(input logic [7:0] x, input string t);
        for (int i = 0; i < 8; i++) send_bit(x[i], t);
    endtask

    task automatic recv_byte(input logic [7:0] x, input string t);
        for (int i = 0; i < 8; i++) begin
            p(pin(1, 0, 0), t);
            put(pin(1, 0, 1), {1'b0, 1'b1, x[i], 1'b1}, t);
        end
    endtask

    task automatic send_cmd(input logic [2:0] sel, input logic rd, input logic msb, input string t);
        logic [7:0] c, r;
        c = {4'h6, sel, rd};
        for (int i = 0; i < 8; i++) r[i] = c[7-i];
        send_byte(msb ? r : c, t);
    endtask

    function automatic int base_of(input logic [2:0] sel);
        return (sel == 3'd2) ? 1 : (sel == 3'd3) ? 5 : 0;
    endfunction

    function automatic int len_of(input logic [2:0] sel);
        return (sel == 3'd2) ? 7 : (sel == 3'd3) ? 3 : 1;
    endfunction

    task automatic write_reg(input logic [2:0] sel, input logic msb, input string t);
        start_cmd(t);
        send_cmd(sel, 1'b0, msb, t);
        for (int k = 0; k < len_of(sel); k++) begin
            send_byte(wb[k], t);
            mdl[base_of(sel) + k] = wb[k];
        end
        end_xfer(t);
    endtask

    task automatic read_reg(input logic [2:0] sel, input logic msb, input string t);
        start_cmd(t);
        send_cmd(sel, 1'b1, msb, t);
        for (int k = 0; k < len_of(sel); k++) recv_byte(mdl[base_of(sel) + k], t);
        end_xfer(t);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 8; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_vec++;
        if (data_q !== 4'h0) begin
            n_bad++;
            $display("FAIL R10: data_q=%h expected 0", data_q);
        end

        // R1: masking, bit 3 pass-through
        p(4'hF, "R1");
        set_dir(4'hF);
        p(4'hA, "R1");
        set_dir(4'b0111);
        p(pin(0, 0, 1), "R1");

        // R10: clock bytes start at zero
        read_reg(3'd1, 1'b0, "R10");
        read_reg(3'd2, 1'b0, "R10");

        // R6/R4: control written LSB-first command, read with mirrored command
        wb[0] = 8'h5A;
        write_reg(3'd1, 1'b0, "R6");
        read_reg(3'd1, 1'b1, "R4");

        // R6/R7: calendar write, views read back
        wb[0] = 8'h24; wb[1] = 8'h07; wb[2] = 8'h19; wb[3] = 8'h03;
        wb[4] = 8'h13; wb[5] = 8'h45; wb[6] = 8'h59;
        write_reg(3'd2, 1'b1, "R6");
        read_reg(3'd3, 1'b0, "R7");
        read_reg(3'd2, 1'b0, "R7");
        wb[0] = 8'h08; wb[1] = 8'h30; wb[2] = 8'h01;
        write_reg(3'd3, 1'b0, "R6");
        read_reg(3'd2, 1'b1, "R6");

        // R5: reset command clears control only
        wb[0] = 8'hA5;
        write_reg(3'd1, 1'b0, "R5");
        start_cmd("R5");
        send_cmd(3'd0, 1'b0, 1'b0, "R5");
        mdl[0] = 8'h00;
        end_xfer("R5");
        read_reg(3'd1, 1'b0, "R5");
        read_reg(3'd2, 1'b0, "R5");
        wb[0] = 8'hA5;
        write_reg(3'd1, 1'b0, "R5");

        // R8: unknown select
        start_cmd("R8");
        send_cmd(3'd5, 1'b0, 1'b0, "R8");
        send_byte(8'h33, "R8");
        end_xfer("R8");
        read_reg(3'd1, 1'b0, "R8");
        read_reg(3'd2, 1'b0, "R8");

        // R2: chip select rising while clock low opens nothing
        p(pin(0, 0, 0), "R2");
        p(pin(1, 0, 0), "R2");
        send_cmd(3'd1, 1'b0, 1'b0, "R2");
        send_byte(8'hFF, "R2");
        end_xfer("R2");
        read_reg(3'd1, 1'b0, "R2");

        // R9: abort mid-byte, and abort coinciding with the last clock rise
        start_cmd("R9");
        send_cmd(3'd1, 1'b0, 1'b0, "R9");
        for (int i = 0; i < 4; i++) send_bit(1'b1, "R9");
        end_xfer("R9");
        read_reg(3'd1, 1'b0, "R9");
        start_cmd("R9");
        send_cmd(3'd1, 1'b0, 1'b0, "R9");
        for (int i = 0; i < 7; i++) send_bit(1'b0, "R9");
        p(pin(1, 0, 0), "R9");
        p(pin(0, 0, 1), "R9");
        read_reg(3'd1, 1'b0, "R9");
        start_cmd("R9");
        send_cmd(3'd3, 1'b1, 1'b0, "R9");
        recv_byte(mdl[5], "R9");
        end_xfer("R9");
        read_reg(3'd3, 1'b0, "R9");

        repeat (4) @(negedge clk);
        summary();
    end
endmodule